// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of its interrupt sources is served next. Each source is built as one of two kinds, chosen per source by a parameter. A flag-type source watches for rising edges on its input and records each one in a sticky pending flag. A level-type source keeps no state and asks for service only while its input is high. Each source has its own enable. A single global enable gates all of them.

When servicing is allowed and at least one enabled source is asking, the controller picks the source with the lowest index. It presents that source's number and vector address to the core and clears the global enable. It holds both values stable until the core answers with an acknowledge pulse. The acknowledge clears the flag of a flag-type source. The core reports three events: return-from-interrupt, set-enable and clear-enable. It also reports each completed main-program instruction, which the controller uses to enforce a one-instruction gap after every return. A base-select input moves the vector table from address zero to a parameter-given boot address.

Top module: `pic_vec_ctrl`

## Requirements
- R1: When several enabled sources request at once, the lowest source index is presented first. The others are presented later, one at a time, in rising index order.
- R2: A source is presented only if its own enable bit and the global enable are both 1. A masked flag-type request stays pending and is presented once its enable is set.
- R3: Presenting a request clears the global enable. A return-from-interrupt pulse or a set-enable pulse sets it again on the next clock edge.
- R4: A rising edge on a flag-type input sets that source's pending flag, shown on `pend` one edge later, even when the source or the global enable is off. The flag stays set until it is cleared.
- R5: A 1 in bit i of `flag_clr` during a clock edge clears pending flag i, unless a new edge on that source arrives in the same cycle.
- R6: A level-type source never sets a pending flag. If its input drops before it is presented, no interrupt results.
- R7: After a return-from-interrupt pulse, no request is presented until at least one `insn_done` pulse has been seen in a later cycle.
- R8: A clear-enable pulse blocks presentation in the same cycle it is applied, and in every later cycle until the global enable is set again.
- R9: With `boot_sel` at 1, vector addresses are offset by the parameter BOOT_BASE. With `boot_sel` at 0, they start from address 0.
- R10: The vector for source i is base + 2·(i+1), and base itself is the reset slot. After reset, `irq_req`, `gie` and `pend` are all 0.
- R11: `irq_req`, `irq_idx` and `irq_vec` hold steady until `irq_ack`. The acknowledge drops `irq_req` and clears the presented source's pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Source inputs: edge events for flag-type sources, conditions for level-type sources |
| src_en | input | N_SRC | Per-source enable |
| flag_clr | input | N_SRC | Write-one-to-clear strobes for pending flags |
| gie_set | input | 1 | Set-global-enable event |
| gie_clr | input | 1 | Clear-global-enable event, effective in the same cycle |
| reti | input | 1 | Return-from-interrupt event |
| insn_done | input | 1 | One main-program instruction completed |
| boot_sel | input | 1 | Vector table base select |
| irq_ack | input | 1 | Acknowledge of the presented request |
| irq_req | output | 1 | A request is being presented |
| irq_idx | output | IDX_W | Index of the presented source |
| irq_vec | output | ADDR_W | Vector address of the presented source |
| gie | output | 1 | Global enable state |
| pend | output | N_SRC | Pending flags |

## Verification
Two flag-type sources are raised while the global enable is off. This shows whether events are latched while masked and whether they are then served in index order rather than in arrival order. A pending request is held behind a return until the first completed instruction, which separates a correct one-instruction gap from an immediate re-entry. A short level pulse that ends before the enable rises is contrasted with a level held high, to tell a stateless level source from one that latches. A clear-enable pulse that coincides with a new request, and a vector drawn with the boot base selected, cover same-cycle masking and address generation.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic {
      ST_IDLE    = 1'b0,
      ST_PRESENT = 1'b1
   } pic_state_e;

   // two instruction words per slot, slot 0 is the reset entry
   function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                             input logic [31:0] idx);
      return base + ((idx + 32'd1) << 1);
   endfunction

endpackage

// File: rtl/pic_src_latch.sv
module pic_src_latch #(
   parameter int               N_SRC      = 8,
   parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_in,
   input  logic [N_SRC-1:0] src_en,
   input  logic [N_SRC-1:0] flag_clr,
   input  logic [N_SRC-1:0] ack_oh,
   output logic [N_SRC-1:0] flag_q,
   output logic [N_SRC-1:0] req
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (LEVEL_MASK[i]) begin : g_lvl
         logic unused_lvl;
         assign unused_lvl = flag_clr[i] ^ ack_oh[i];
         assign flag_q[i]  = 1'b0;
         assign req[i]     = src_in[i] & src_en[i];
      end else begin : g_edge
         logic d_q, f_q, rise;
         assign rise = src_in[i] & ~d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= 1'b0;
               f_q <= 1'b0;
            end else begin
               d_q <= src_in[i];
               if (rise)
                  f_q <= 1'b1;
               else if (flag_clr[i] | ack_oh[i])
                  f_q <= 1'b0;
            end
         end
         assign flag_q[i] = f_q;
         assign req[i]    = f_q & src_en[i];

         p_edge_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (src_in[i] && !d_q) |=> f_q);
         p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[i] && !(src_in[i] && !d_q)) |=> !f_q);
      end
   end

endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
   parameter int N_SRC = 8,
   parameter int IDX_W = 3
) (
   input  logic [N_SRC-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/pic_gate.sv
module pic_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic gie_set,
   input  logic gie_clr,
   input  logic reti,
   input  logic insn_done,
   input  logic take,
   output logic gie_q,
   output logic allow
);

   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (gie_clr)
            gie_q <= 1'b0;
         else if (take)
            gie_q <= 1'b0;
         else if (reti | gie_set)
            gie_q <= 1'b1;

         if (reti)
            hold_q <= 1'b1;
         else if (insn_done)
            hold_q <= 1'b0;
      end
   end

   assign allow = gie_q & ~gie_clr & ~hold_q & ~reti;

   p_hold_after_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reti |=> !allow);

endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl #(
   parameter int               N_SRC      = 8,
   parameter int               ADDR_W     = 16,
   parameter logic [31:0]      BOOT_BASE  = 32'h0000_1E00,
   parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hC0,
   localparam int              IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_in,
   input  logic [N_SRC-1:0]  src_en,
   input  logic [N_SRC-1:0]  flag_clr,
   input  logic              gie_set,
   input  logic              gie_clr,
   input  logic              reti,
   input  logic              insn_done,
   input  logic              boot_sel,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [IDX_W-1:0]  irq_idx,
   output logic [ADDR_W-1:0] irq_vec,
   output logic              gie,
   output logic [N_SRC-1:0]  pend
);
   import pic_pkg::*;

   localparam logic [31:0] TOP_ADDR = BOOT_BASE + 32'(2 * (N_SRC + 1));

   if (N_SRC < 1 || N_SRC > 32) begin : g_bad_n
      $error("N_SRC must lie in 1..32");
   end
   if (BOOT_BASE[0]) begin : g_bad_base
      $error("BOOT_BASE must be word-pair aligned");
   end
   if (ADDR_W < 32 && (TOP_ADDR >> ADDR_W) != 0) begin : g_bad_aw
      $error("ADDR_W too narrow for the vector table");
   end

   pic_state_e             state_q;
   logic [IDX_W-1:0]       cur_q;
   logic [ADDR_W-1:0]      vec_q;
   logic [N_SRC-1:0]       req_vec, ack_oh;
   logic                   any_req, allow, take, ack_stb;
   logic [IDX_W-1:0]       pick_idx;
   logic [31:0]            base_sel;

   assign ack_stb = (state_q == ST_PRESENT) & irq_ack;
   assign ack_oh  = ack_stb ? (N_SRC'(1) << cur_q) : '0;

   pic_src_latch #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_in   (src_in),
      .src_en   (src_en),
      .flag_clr (flag_clr),
      .ack_oh   (ack_oh),
      .flag_q   (pend),
      .req      (req_vec)
   );

   pic_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_enc (
      .req (req_vec),
      .any (any_req),
      .idx (pick_idx)
   );

   assign take = (state_q == ST_IDLE) & allow & any_req;

   pic_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .gie_set   (gie_set),
      .gie_clr   (gie_clr),
      .reti      (reti),
      .insn_done (insn_done),
      .take      (take),
      .gie_q     (gie),
      .allow     (allow)
   );

   assign base_sel = boot_sel ? BOOT_BASE : 32'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         vec_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (take) begin
               state_q <= ST_PRESENT;
               cur_q   <= pick_idx;
               vec_q   <= ADDR_W'(slot_addr(base_sel, 32'(pick_idx)));
            end
            ST_PRESENT: if (irq_ack) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign irq_req = (state_q == ST_PRESENT);
   assign irq_idx = cur_q;
   assign irq_vec = vec_q;

   // lowest pending index wins
   p_lowest_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> (req_vec[pick_idx] &&
                   ((req_vec & ((N_SRC'(1) << pick_idx) - N_SRC'(1))) == '0)));
   p_needs_gie_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !$past(irq_req)) |-> $past(gie));
   p_entry_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !$past(irq_req)) |-> !gie);
   p_ret_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !irq_req) |=> !irq_req);
   p_clr_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_clr && !irq_req) |=> !irq_req);
   p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_idx)));
   p_ack_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack) |=> !irq_req);

endmodule

// File: tb/sim_pic_vec_ctrl.sv
module sim_pic_vec_ctrl;
   localparam int          N     = 8;
   localparam int          AW    = 16;
   localparam logic [31:0] BBASE = 32'h0000_1E00;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_in = '0, src_en = '1, flag_clr = '0;
   logic          gie_set = 0, gie_clr = 0, reti = 0, insn_done = 0, boot_sel = 0;
   logic          irq_ack = 0;
   logic          irq_req, gie;
   logic [2:0]    irq_idx;
   logic [AW-1:0] irq_vec;
   logic [N-1:0]  pend;

   int n_chk = 0, n_bad = 0;
   int exp_q[$];
   bit done = 0;

   always #10 clk = ~clk;

   pic_vec_ctrl #(.N_SRC(N), .ADDR_W(AW), .BOOT_BASE(BBASE), .LEVEL_MASK(8'hC0)) u0 (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en), .flag_clr(flag_clr),
      .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti), .insn_done(insn_done),
      .boot_sel(boot_sel), .irq_ack(irq_ack), .irq_req(irq_req), .irq_idx(irq_idx),
      .irq_vec(irq_vec), .gie(gie), .pend(pend));

   function automatic int vexp(int idx, bit boot);
      return (boot ? int'(BBASE) : 0) + 2 * (idx + 1);
   endfunction

   task automatic chk(string req, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_src(int i);
      src_in[i] = 1'b1; step(1); src_in[i] = 1'b0;
   endtask

   task automatic pulse_set();
      gie_set = 1; step(1); gie_set = 0;
   endtask

   // monitor: pops expected vector whenever a request is presented, then acks
   always @(negedge clk) begin
      if (rst_n && irq_req && !irq_ack) begin
         if (exp_q.size() == 0) begin
            chk("R2 unexpected request", int'(irq_vec), 0);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk("R1 R9 R10 vector", int'(irq_vec), e);
         end
         irq_ack = 1'b1;
      end else begin
         irq_ack = 1'b0;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R10 reset state
      chk("R10 irq_req after reset", irq_req, 0);
      chk("R10 gie after reset", gie, 0);
      chk("R10 pend after reset", pend, 0);

      // R4: edges latched while masked
      pulse_src(5);
      pulse_src(2);
      step(1);
      chk("R4 flags latched while masked", pend, 8'h24);
      chk("R2 no request with gie off", irq_req, 0);

      // R1: serve 2 first, then 5
      exp_q.push_back(vexp(2, 0));
      exp_q.push_back(vexp(5, 0));
      pulse_set();
      step(2);
      chk("R3 entry clears gie", gie, 0);
      chk("R11 ack clears flag 2", pend, 8'h20);

      // R7: return, then gap until an instruction completes
      reti = 1; step(1); reti = 0;
      chk("R3 return sets gie", gie, 1);
      step(3);
      chk("R7 no entry before instruction", irq_req, 0);
      chk("R7 flag 5 still pending", pend, 8'h20);
      insn_done = 1; step(1); insn_done = 0;
      step(2);
      chk("R11 ack clears flag 5", pend, 0);

      // R5: write-one-to-clear
      pulse_src(3);
      step(1);
      chk("R5 flag 3 set", pend, 8'h08);
      flag_clr = 8'h08; step(1); flag_clr = '0;
      chk("R5 flag 3 cleared", pend, 0);

      // R2: individual enable
      src_en[4] = 1'b0;
      pulse_src(4);
      pulse_set();
      step(3);
      chk("R2 masked source not taken", irq_req, 0);
      chk("R2 masked flag stays", pend, 8'h10);
      exp_q.push_back(vexp(4, 0));
      src_en[4] = 1'b1;
      step(3);
      chk("R2 flag 4 served after enable", pend, 0);

      // R6: short level pulse leaves nothing behind
      src_in[6] = 1'b1; step(2); src_in[6] = 1'b0;
      step(1);
      chk("R6 level source sets no flag", pend, 0);
      pulse_set();
      step(3);
      chk("R6 vanished level gives no request", irq_req, 0);
      exp_q.push_back(vexp(6, 0));
      src_in[6] = 1'b1;
      step(2);
      src_in[6] = 1'b0;
      step(1);
      chk("R6 held level served", exp_q.size(), 0);

      // R8: clear-enable in the same cycle as a request
      pulse_set();
      src_in[7] = 1'b1; gie_clr = 1; step(1); gie_clr = 0;
      step(3);
      chk("R8 request blocked by same-cycle clear", irq_req, 0);
      chk("R8 gie cleared", gie, 0);
      src_in[7] = 1'b0;
      step(1);

      // R9: boot base select
      boot_sel = 1'b1;
      exp_q.push_back(vexp(0, 1));
      pulse_src(0);
      pulse_set();
      step(4);
      chk("R9 boot vector served", pend, 0);
      boot_sel = 1'b0;

      chk("R11 all expected vectors presented", exp_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule